// File: doc/BRIEF.md
# Chained Descriptor DMA Walker

This block is the internal DMA engine of a card host controller. Software builds a list of 16-byte descriptors in system memory and hands over each entry by setting its ownership flag. It then gives the engine the address of the first entry and pulses start. For each descriptor the engine reads all four words and moves the described buffer. Depending on the direction chosen at start, data flows from the receive FIFO into memory or from memory into the transmit FIFO. The engine then writes the control word back with ownership cleared and moves to the next entry. The next entry is either the address held in the descriptor or the slot directly after it.

Descriptor layout: word 0 holds control and status, word 1 holds the buffer byte counts, word 2 holds the buffer address and word 3 holds the next-entry address. A transfer ends after the descriptor flagged as last. An entry that software has not yet handed over stops the engine with a status flag raised until software pulses resume. A software reset pulse abandons the transfer at any point.

Memory traffic uses one request port with a request/grant handshake. Read data returns on a separate valid strobe, and only one read is outstanding at a time. Buffers are word aligned. Full descriptors normally carry 4096 bytes, and only the final one carries a remainder.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset busy_o, unavail_o, irq_o, mem_req_o, tx_valid_o and rx_ready_o are all low.
- R2: A start pulse makes the engine read the descriptor at desc_base_i. The reads go to byte offsets 0, 4, 8 and 12 in that order, one read per grant. A read request keeps its address stable until it is granted.
- R3: If word 0 bit 31 (ownership) reads as 0, no further words are read. unavail_o rises and no request is issued until resume_i. The engine then reads the same descriptor again from offset 0.
- R4: In receive direction (to_mem_i=1 at start), each receive FIFO word is written to the buffer address from word 2 plus 4*i. The number of words is ceil(word1[12:0]/4).
- R5: In transmit direction, the engine reads the same word sequence from memory and presents each word on tx_data_o in order. Each word is held until tx_ready_i.
- R6: After the buffer, the engine writes word 0 back to the descriptor address. Bit 31 is cleared and every other bit is unchanged.
- R7: irq_o pulses for exactly one cycle, in the cycle after a write-back is granted. The pulse is suppressed when word 0 bit 1 is set and bit 2 is clear.
- R8: The next descriptor is read from the word 3 address when word 0 bit 4 (chain) is set. Otherwise it is read from the descriptor address plus 16.
- R9: After the write-back of a descriptor with word 0 bit 2 (last) set, busy_o drops and no more requests are issued.
- R10: A descriptor with a byte count of 0 causes no data traffic: word 0 is written back directly.
- R11: srst_i returns the engine to idle at the next edge, from any state. From the following cycle busy_o and mem_req_o are low.
- R12: start_i has no effect while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk at desc_base_i |
| resume_i | input | 1 | Retry the stalled descriptor |
| srst_i | input | 1 | Software reset pulse, aborts the walk |
| to_mem_i | input | 1 | Direction sampled at start: 1 = FIFO to memory |
| desc_base_i | input | 32 | Address of the first descriptor |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| rx_valid_i | input | 1 | Receive FIFO word available |
| rx_data_i | input | 32 | Receive FIFO word |
| rx_ready_o | output | 1 | Receive FIFO word consumed |
| tx_valid_o | output | 1 | Transmit FIFO word valid |
| tx_data_o | output | 32 | Transmit FIFO word |
| tx_ready_i | input | 1 | Transmit FIFO accepts word |
| busy_o | output | 1 | Walk in progress, including stall |
| unavail_o | output | 1 | Stalled on a descriptor that software still owns |
| irq_o | output | 1 | Descriptor completion pulse |

## Verification
The bench targets these corner cases:
- A 6-byte count that must round up to two words. An engine that truncates would write back one word early.
- A zero-length entry in the middle of a chain. A wrong engine would issue a stray buffer access.
- A mix of chained and sequential entries. A wrong successor choice shows up as a fetch at the wrong address.
- An unowned entry. An engine that ignored ownership would run into the unowned buffer, and one that resumed at the wrong offset would skip word 0.
- A second start while busy, and a software reset in the middle of a buffer. A design that honoured either would issue requests the reference model never predicted.
- The interrupt suppression bit combined with the last flag. A wrong engine would miscount completion pulses.

// File: rtl/dma_walk_pkg.sv
`timescale 1ns/1ps
package dma_walk_pkg;
  // control word bit positions (software-visible layout)
  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned CES_BIT   = 30;
  localparam int unsigned EOR_BIT   = 5;
  localparam int unsigned CHAIN_BIT = 4;
  localparam int unsigned FIRST_BIT = 3;
  localparam int unsigned LAST_BIT  = 2;
  localparam int unsigned NOIRQ_BIT = 1;
  // size word fields
  localparam int unsigned BS1_LSB   = 0;
  localparam int unsigned BS2_LSB   = 13;
  localparam int unsigned BS_W      = 13;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FREQ, ST_FWAIT, ST_STALL,
    ST_RREQ, ST_RWAIT, ST_TXOUT, ST_WXFER, ST_WB
  } walk_st_e;
endpackage

// File: rtl/dma_desc_regs.sv
`timescale 1ns/1ps
module dma_desc_regs #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int SZW = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_i,
  input  logic [1:0]     idx_i,
  input  logic [DW-1:0]  word_i,
  output logic [DW-1:0]  ctl_o,
  output logic [SZW-1:0] size_o,
  output logic [AW-1:0]  buf_o,
  output logic [AW-1:0]  next_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '0;
      size_o <= '0;
      buf_o  <= '0;
      next_o <= '0;
    end else if (ld_i) begin
      unique case (idx_i)
        2'd0: ctl_o  <= word_i;
        2'd1: size_o <= word_i[SZW-1:0];
        2'd2: buf_o  <= word_i[AW-1:0];
        default: next_o <= word_i[AW-1:0];
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_cnt.sv
`timescale 1ns/1ps
module dma_xfer_cnt #(
  parameter int AW  = 32,
  parameter int SZW = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           inc_i,
  input  logic [SZW-1:0] size_i,
  input  logic [AW-1:0]  base_i,
  output logic [AW-1:0]  addr_o,
  output logic           zero_o,
  output logic           last_o
);
  localparam int CW = SZW - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] nwords;
  logic [SZW:0]  sz_rnd;

  // round byte count up to whole words
  assign sz_rnd = {1'b0, size_i} + (SZW+1)'(3);
  assign nwords = CW'(sz_rnd >> 2);
  assign zero_o = (nwords == '0);
  assign last_o = (cnt_q == nwords - CW'(1));
  assign addr_o = base_i + AW'({cnt_q, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/dma_chain_walker.sv
`timescale 1ns/1ps
module dma_chain_walker
  import dma_walk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int SZW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          resume_i,
  input  logic          srst_i,
  input  logic          to_mem_i,
  input  logic [AW-1:0] desc_base_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_ready_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  output logic          busy_o,
  output logic          unavail_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] DESC_STEP = AW'(4 * (DW / 8));
  localparam logic [DW-1:0] OWN_MASK  = DW'(1) << OWN_BIT;

  walk_st_e      st_q;
  logic [1:0]    fidx_q;
  logic [AW-1:0] desc_addr_q;
  logic          dir_q;
  logic          irq_q;
  logic [DW-1:0] txd_q;

  logic [DW-1:0]  ctl_w;
  logic [SZW-1:0] size_w;
  logic [AW-1:0]  buf_w, next_w, xfer_addr;
  logic           xfer_zero, xfer_last;
  logic           fetch_ld, cnt_clr, cnt_inc;

  assign fetch_ld = (st_q == ST_FWAIT) && mem_rvalid_i;
  assign cnt_clr  = (st_q == ST_FWAIT);
  assign cnt_inc  = ((st_q == ST_WXFER) && rx_valid_i && mem_gnt_i) ||
                    ((st_q == ST_TXOUT) && tx_ready_i);

  dma_desc_regs #(.AW(AW), .DW(DW), .SZW(SZW)) u_desc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (fetch_ld),
    .idx_i  (fidx_q),
    .word_i (mem_rdata_i),
    .ctl_o  (ctl_w),
    .size_o (size_w),
    .buf_o  (buf_w),
    .next_o (next_w)
  );

  dma_xfer_cnt #(.AW(AW), .SZW(SZW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .size_i (size_w),
    .base_i (buf_w),
    .addr_o (xfer_addr),
    .zero_o (xfer_zero),
    .last_o (xfer_last)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_FREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr_q + AW'({fidx_q, 2'b00});
      end
      ST_RREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = xfer_addr;
      end
      ST_WXFER: begin
        mem_req_o   = rx_valid_i;
        mem_we_o    = 1'b1;
        mem_addr_o  = xfer_addr;
        mem_wdata_o = rx_data_i;
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr_q;
        mem_wdata_o = ctl_w & ~OWN_MASK;
      end
      default: ;
    endcase
  end

  assign rx_ready_o = (st_q == ST_WXFER) && mem_gnt_i;
  assign tx_valid_o = (st_q == ST_TXOUT);
  assign tx_data_o  = txd_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign unavail_o  = (st_q == ST_STALL);
  assign irq_o      = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      fidx_q      <= '0;
      desc_addr_q <= '0;
      dir_q       <= 1'b0;
      irq_q       <= 1'b0;
      txd_q       <= '0;
    end else if (srst_i) begin
      st_q  <= ST_IDLE;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          desc_addr_q <= desc_base_i;
          dir_q       <= to_mem_i;
          fidx_q      <= '0;
          st_q        <= ST_FREQ;
        end
        ST_FREQ: if (mem_gnt_i) st_q <= ST_FWAIT;
        ST_FWAIT: if (mem_rvalid_i) begin
          if (fidx_q == 2'd0 && !mem_rdata_i[OWN_BIT]) st_q <= ST_STALL;
          else if (fidx_q == 2'd3)
            st_q <= xfer_zero ? ST_WB : (dir_q ? ST_WXFER : ST_RREQ);
          else begin
            fidx_q <= fidx_q + 2'd1;
            st_q   <= ST_FREQ;
          end
        end
        ST_STALL: if (resume_i) begin
          fidx_q <= '0;
          st_q   <= ST_FREQ;
        end
        ST_RREQ:  if (mem_gnt_i) st_q <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid_i) begin
          txd_q <= mem_rdata_i;
          st_q  <= ST_TXOUT;
        end
        ST_TXOUT: if (tx_ready_i) st_q <= xfer_last ? ST_WB : ST_RREQ;
        ST_WXFER: if (rx_valid_i && mem_gnt_i && xfer_last) st_q <= ST_WB;
        ST_WB: if (mem_gnt_i) begin
          irq_q <= !ctl_w[NOIRQ_BIT] || ctl_w[LAST_BIT];
          if (ctl_w[LAST_BIT]) st_q <= ST_IDLE;
          else begin
            desc_addr_q <= ctl_w[CHAIN_BIT] ? next_w : desc_addr_q + DESC_STEP;
            fidx_q      <= '0;
            st_q        <= ST_FREQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_walker_chk.sv
`timescale 1ns/1ps
module dma_chain_walker_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          srst_i,
  input logic          resume_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_gnt_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [DW-1:0] tx_data_o,
  input logic          busy_o,
  input logic          unavail_o,
  input logic          irq_o
);
  p_stall_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_o |-> !mem_req_o);

  p_stall_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_o && !resume_i && !srst_i |=> unavail_o);

  p_rd_req_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && !mem_gnt_i && !srst_i |=> mem_req_o && $stable(mem_addr_o));

  p_tx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !srst_i |=> tx_valid_o && $stable(tx_data_o));

  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_after_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_req_o && mem_we_o && mem_gnt_i));

  p_idle_no_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  p_srst_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !busy_o && !mem_req_o);
endmodule

bind dma_chain_walker dma_chain_walker_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dma_chain_walker_tb.sv
`timescale 1ns/1ps
module dma_chain_walker_tb;
  localparam int MEMW = 1024;
  localparam logic [31:0] OWN = 32'h8000_0000, CHN = 32'h10, FST = 32'h8,
                          LST = 32'h4, NIQ = 32'h2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, resume = 1'b0, srst = 1'b0, to_mem = 1'b0;
  logic [31:0] base = '0;
  logic mem_req, mem_we, mem_gnt, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic rx_valid = 1'b0, rx_ready, tx_valid, tx_ready, busy, unavail, irq;
  logic [31:0] rx_data = '0, tx_data;

  logic [31:0] mem [MEMW];
  logic [31:0] rx_buf [64];
  int rx_rd = 0, rx_n = 0;
  int unsigned cyc = 0;
  int n_chk = 0, n_err = 0, irq_cnt = 0, exp_irq = 0;
  bit chk_on = 1'b1;

  logic        exp_we[$];
  logic [31:0] exp_addr[$], exp_data[$], exp_tx[$];
  string       exp_tag[$];

  always #2 clk = ~clk;

  assign mem_gnt  = (cyc % 3) != 2;
  assign tx_ready = (cyc % 2) == 0;

  dma_chain_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .resume_i(resume), .srst_i(srst),
    .to_mem_i(to_mem), .desc_base_i(base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .busy_o(busy), .unavail_o(unavail), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory, rx source and cycle counter: flop models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:2]];
      end
    end
    if (rx_valid && rx_ready) rx_rd = rx_rd + 1;
    rx_valid <= (rx_rd < rx_n);
    rx_data  <= rx_buf[rx_rd[5:0]];
  end

  // reference comparison each clock, away from the edge
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      if (mem_req && mem_gnt) begin
        if (exp_addr.size() == 0) chk(1'b0, "R9", "unexpected request", mem_addr, 32'h0);
        else begin
          logic        ew;
          logic [31:0] ea, ed;
          string       et;
          ew = exp_we.pop_front(); ea = exp_addr.pop_front();
          ed = exp_data.pop_front(); et = exp_tag.pop_front();
          chk(mem_we == ew, et, "request kind", {31'b0, mem_we}, {31'b0, ew});
          chk(mem_addr == ea, et, "request address", mem_addr, ea);
          if (ew) chk(mem_wdata == ed, et, "write data", mem_wdata, ed);
        end
      end
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) chk(1'b0, "R5", "unexpected tx word", tx_data, 32'h0);
        else begin
          logic [31:0] et;
          et = exp_tx.pop_front();
          chk(tx_data == et, "R5", "tx word", tx_data, et);
        end
      end
      if (irq) irq_cnt++;
    end
  end

  task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d, input string t);
    exp_we.push_back(we); exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] sz,
                          input logic [31:0] b, input logic [31:0] nx);
    mem[a[11:2]] = w0; mem[a[11:2] + 10'd1] = sz;
    mem[a[11:2] + 10'd2] = b; mem[a[11:2] + 10'd3] = nx;
    for (int i = 0; i < 16; i++) mem[b[11:2] + 10'(i)] = b ^ (32'h0101_0000 * 32'(i + 1)) ^ 32'h5A00_0000;
  endtask

  // walks the bench's own memory image and predicts all traffic
  task automatic plan(input logic [31:0] a0, input bit dir, output bit stalled, output logic [31:0] at);
    logic [31:0] d, w0, b;
    int n;
    d = a0; stalled = 1'b0; at = '0;
    for (int k = 0; k < 16; k++) begin
      w0 = mem[d[11:2]];
      push(1'b0, d, '0, (k == 0) ? "R2" : "R8");
      if (!w0[31]) begin stalled = 1'b1; at = d; return; end
      for (int j = 1; j < 4; j++) push(1'b0, d + 32'(4 * j), '0, "R2");
      n = (int'(mem[d[11:2] + 10'd1][12:0]) + 3) / 4;
      b = mem[d[11:2] + 10'd2];
      for (int i = 0; i < n; i++) begin
        if (dir) begin
          rx_buf[rx_n[5:0]] = 32'hC0DE_0000 + 32'(rx_n);
          push(1'b1, b + 32'(4 * i), 32'hC0DE_0000 + 32'(rx_n), "R4");
          rx_n++;
        end else begin
          push(1'b0, b + 32'(4 * i), '0, "R5");
          exp_tx.push_back(mem[b[11:2] + 10'(i)]);
        end
      end
      push(1'b1, d, w0 & ~OWN, (n == 0) ? "R10" : "R6");
      if (!w0[1] || w0[2]) exp_irq++;
      if (w0[2]) break;
      d = w0[4] ? mem[d[11:2] + 10'd3] : d + 32'd16;
    end
  endtask

  task automatic clear_model();
    exp_we.delete(); exp_addr.delete(); exp_data.delete(); exp_tag.delete(); exp_tx.delete();
    exp_irq = 0; irq_cnt = 0; rx_n = 0; rx_rd = 0;
  endtask

  task automatic pulse_start(input logic [31:0] a, input bit dir);
    @(negedge clk); base = a; to_mem = dir; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (!busy || unavail) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_checks(input string req);
    repeat (4) @(negedge clk);
    chk(!busy, "R9", "busy after last", {31'b0, busy}, 32'h0);
    chk(exp_addr.size() == 0, req, "predicted requests left", 32'(exp_addr.size()), 32'h0);
    chk(exp_tx.size() == 0, req, "predicted tx words left", 32'(exp_tx.size()), 32'h0);
    chk(irq_cnt == exp_irq, "R7", "completion pulses", 32'(irq_cnt), 32'(exp_irq));
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
    report();
    $finish;
  end

  initial begin
    bit st;
    logic [31:0] sa;
    for (int i = 0; i < MEMW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !unavail && !irq, "R1", "status at reset", {29'b0, busy, unavail, irq}, 32'h0);
    chk(!mem_req && !tx_valid && !rx_ready, "R1", "handshakes at reset",
        {29'b0, mem_req, tx_valid, rx_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1", "idle after release", {30'b0, busy, mem_req}, 32'h0);

    // R5 R8 R7 R12: chained transmit, odd tail, suppressed interrupt, start while busy
    clear_model();
    set_desc(32'h000, OWN | CHN | FST, 32'd8,  32'h400, 32'h040);
    set_desc(32'h040, OWN | CHN | NIQ, 32'd12, 32'h500, 32'h080);
    set_desc(32'h080, OWN | LST,       32'd6,  32'h600, 32'h0);
    set_desc(32'h300, OWN | LST | FST, 32'd4,  32'h700, 32'h0);
    plan(32'h000, 1'b0, st, sa);
    pulse_start(32'h000, 1'b0);
    repeat (6) @(negedge clk);
    base = 32'h300; start = 1'b1;         // R12: must be ignored
    @(negedge clk); start = 1'b0;
    wait_done();
    finish_checks("R12");
    chk(mem[32'h080 >> 2] == LST, "R6", "written-back control word", mem[32'h080 >> 2], LST);
    chk(mem[32'h300 >> 2] == (OWN | LST | FST), "R12", "untouched descriptor",
        mem[32'h300 >> 2], OWN | LST | FST);

    // R4 R8: receive direction, sequential successor
    clear_model();
    set_desc(32'h100, OWN | FST, 32'd16, 32'h800, 32'hFFC);
    set_desc(32'h110, OWN | LST, 32'd8,  32'h880, 32'h0);
    plan(32'h100, 1'b1, st, sa);
    pulse_start(32'h100, 1'b1);
    wait_done();
    finish_checks("R4");
    for (int i = 0; i < 4; i++)
      chk(mem[10'h200 + 10'(i)] == 32'hC0DE_0000 + 32'(i), "R4", "buffer word",
          mem[10'h200 + 10'(i)], 32'hC0DE_0000 + 32'(i));
    chk(mem[10'h221] == 32'hC0DE_0005, "R4", "second buffer word", mem[10'h221], 32'hC0DE_0005);
    chk(mem[32'h100 >> 2] == FST, "R6", "written-back control word", mem[32'h100 >> 2], FST);

    // R10: zero-length entry inside a chain
    clear_model();
    set_desc(32'h180, OWN | CHN | FST, 32'd0, 32'h900, 32'h1A0);
    set_desc(32'h1A0, OWN | LST,       32'd4, 32'h900, 32'h0);
    plan(32'h180, 1'b0, st, sa);
    pulse_start(32'h180, 1'b0);
    wait_done();
    finish_checks("R10");

    // R3: unowned entry stalls, resume refetches it
    clear_model();
    set_desc(32'h200, OWN | CHN | FST, 32'd4, 32'h940, 32'h220);
    set_desc(32'h220, LST,             32'd4, 32'h980, 32'h0);
    plan(32'h200, 1'b0, st, sa);
    chk(st && sa == 32'h220, "R3", "bench plan stall point", sa, 32'h220);
    pulse_start(32'h200, 1'b0);
    wait_done();
    repeat (8) begin
      @(negedge clk);
      chk(unavail && busy && !mem_req, "R3", "stalled quiet",
          {29'b0, unavail, busy, mem_req}, 32'h6);
    end
    chk(exp_addr.size() == 0, "R3", "requests before resume", 32'(exp_addr.size()), 32'h0);
    mem[32'h220 >> 2] = OWN | LST;
    plan(32'h220, 1'b0, st, sa);
    resume = 1'b1;
    @(negedge clk); resume = 1'b0;
    chk(!unavail, "R3", "flag clears on resume", {31'b0, unavail}, 32'h0);
    wait_done();
    finish_checks("R3");

    // R11: software reset in mid-buffer
    clear_model();
    chk_on = 1'b0;
    set_desc(32'h240, OWN | LST | FST, 32'd64, 32'hA00, 32'h0);
    pulse_start(32'h240, 1'b0);
    repeat (20) @(negedge clk);
    chk(busy, "R11", "busy before abort", {31'b0, busy}, 32'h1);
    srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    chk(!busy && !mem_req && !tx_valid, "R11", "idle after abort",
        {29'b0, busy, mem_req, tx_valid}, 32'h0);
    repeat (10) begin
      @(negedge clk);
      chk(!mem_req && !busy, "R11", "quiet after abort", {30'b0, mem_req, busy}, 32'h0);
    end
    chk_on = 1'b1;

    // R2 R11: clean walk after abort
    clear_model();
    set_desc(32'h180, OWN | CHN | FST, 32'd0, 32'h900, 32'h1A0);
    set_desc(32'h1A0, OWN | LST,       32'd4, 32'h900, 32'h0);
    plan(32'h180, 1'b0, st, sa);
    pulse_start(32'h180, 1'b0);
    wait_done();
    finish_checks("R11");

    report();
    $finish;
  end
endmodule